// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block turns one internal read or write request at a time into a timed cycle on an external memory bus. Internally a requester raises a request with address, write data and byte enables and holds it until a one-cycle acknowledge returns. For reads, the acknowledge comes with the read data. Externally the block drives an address bus, a shared address/data bus with output enable, an address-latch strobe (ALE), read and write strobes and a chip select. It samples a READY input.

A single window configuration register shapes every cycle. It selects the bus width and whether address and data share the AD lines. It also sets the number of wait states, an optional idle cycle after the strobe for the bus to float, early release of the write strobe, and a two-cycle ALE. Further bits select READY-controlled stretching, whether chip select follows the read or write strobe, and whether the bus may run at all. The sequencer copies the register at the start of each cycle, so a write to it only affects the next cycle. One timing unit equals one clock.

Top module: `ebs_top`

## Requirements
- R1: Reset loads the configuration register as follows. `cfg[1:0]` (bus mode) comes from `strap_mode_i`. `cfg[8]` (long ALE) and `cfg[12]` (bus enable) are 1. All other bits are 0: `cfg[5:2]` wait states, `cfg[6]` skip-float-wait, `cfg[7]` early write, `cfg[9]` READY enable, `cfg[10]` read-gated CS and `cfg[11]` write-gated CS. `cfg_we_i` writes the whole register.
- R2: The bus mode encoding is 00 = 8-bit demultiplexed, 01 = 8-bit multiplexed, 10 = 16-bit demultiplexed and 11 = 16-bit multiplexed. A 16-bit read returns `ad_i[15:0]`. An 8-bit read returns `ad_i[7:0]` in both bytes of `rdata_o`.
- R3: In multiplexed modes, AD carries `addr[15:0]` (enabled) during ALE. Then AD floats for a read strobe or carries write data for a write strobe. In demultiplexed modes, AD never carries the address and is driven only with write data. `addr_o` holds the request address for the whole cycle. AD is never enabled while RD is active.
- R4: ALE lasts 1 cycle, or 2 cycles when long ALE is set. The strobe starts in the cycle right after ALE ends.
- R5: The read strobe lasts 2 + wait-state cycles.
- R6: With skip-float-wait at 0, one idle cycle follows the strobe. The acknowledge comes in the cycle after the last strobe or idle cycle. So the latency from the request edge is ALE + strobe + idle + 1.
- R7: With early write set, the write strobe is one cycle shorter than the read strobe.
- R8: With READY enabled, the strobe is held once the wait states have elapsed, until READY is sampled high. One final strobe cycle follows. With READY disabled, the READY input has no effect.
- R9: With CS ungated, CS is active through ALE and strobe. With read gating set, on reads CS equals RD. With write gating set, on writes CS equals the active write strobe.
- R10: While bus enable is 0, a pending request starts no cycle: no ALE and no acknowledge. The request starts once the bus is enabled again.
- R11: An 8-bit bus writes with WR alone. For the byte lane it uses `wdata[15:8]` when `be` = 10 and `wdata[7:0]` otherwise. A 16-bit bus writes with WRL for `be[0]` and WRH for `be[1]`, never WR.
- R12: The acknowledge is a single-cycle pulse. A request is not accepted in the acknowledge cycle, so a back-to-back request costs one extra cycle. RD and the write strobes are never active together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, one timing unit per cycle |
| rst_ni | input | 1 | Synchronous reset, active low |
| strap_mode_i | input | 2 | Bus mode loaded at reset |
| cfg_we_i | input | 1 | Configuration register write enable |
| cfg_wdata_i | input | 13 | Configuration write value |
| cfg_rdata_o | output | 13 | Configuration register value |
| req_i | input | 1 | Transfer request, held until acknowledge |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW (20) | Request address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte enables |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read data, valid with acknowledge |
| addr_o | output | AW (20) | External address lines |
| ad_o | output | 16 | Address/data bus output value |
| ad_oe_o | output | 1 | Address/data bus output enable |
| ad_i | input | 16 | Address/data bus input value |
| ale_o | output | 1 | Address latch strobe |
| rd_o | output | 1 | Read strobe |
| wr_o | output | 1 | Write strobe, 8-bit bus |
| wrl_o | output | 1 | Low-byte write strobe, 16-bit bus |
| wrh_o | output | 1 | High-byte write strobe, 16-bit bus |
| cs_o | output | 1 | Chip select |
| ready_i | input | 1 | External ready |

## Verification
The bench builds the block with its default widths: a 20-bit address and a 4-bit wait-state field. With these, strobes from 2 up to 17 cycles are reachable, including the longest wait setting. The 20-bit address puts bits above the 16 carried on AD. This shows that the external address lines keep the full address while AD carries only its low half. All four bus modes are covered, together with every combination of ALE length, float wait, early write, READY and CS gating that the vector table and directed cases select.

// File: rtl/ebs_pkg.sv
package ebs_pkg;

    parameter int WAIT_W = 4;
    parameter int BUS_W  = 16;
    parameter int CFG_W  = WAIT_W + 9;

    typedef enum logic [1:0] {
        BUS_8_DEMUX  = 2'b00,
        BUS_8_MUX    = 2'b01,
        BUS_16_DEMUX = 2'b10,
        BUS_16_MUX   = 2'b11
    } bus_mode_e;

    // mode[0] = shared address/data lines, mode[1] = 16-bit wide
    typedef struct packed {
        logic              bus_on;
        logic              cs_wr_gate;
        logic              cs_rd_gate;
        logic              rdy_en;
        logic              ale_long;
        logic              early_wr;
        logic              no_float_wait;
        logic [WAIT_W-1:0] waits;
        bus_mode_e         mode;
    } win_cfg_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ALE  = 2'd1,
        PH_STRB = 2'd2,
        PH_TRI  = 2'd3
    } phase_e;

endpackage

// File: rtl/ebs_cfg_reg.sv
module ebs_cfg_reg
    import ebs_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic [1:0] strap_mode_i,
    input  logic      wr_en_i,
    input  win_cfg_t  wr_data_i,
    output win_cfg_t  cfg_o
);

    win_cfg_t cfg_d, cfg_q;

    function automatic win_cfg_t reset_value(input logic [1:0] strap);
        win_cfg_t v;
        v          = '0;
        v.bus_on   = 1'b1;
        v.ale_long = 1'b1;
        v.mode     = bus_mode_e'(strap);
        return v;
    endfunction

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            cfg_d = wr_data_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cfg_q <= reset_value(strap_mode_i);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/ebs_seq.sv
module ebs_seq
    import ebs_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  win_cfg_t         cfg_i,
    input  logic             req_i,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic [1:0]       be_i,
    input  logic             ready_i,
    input  logic [BUS_W-1:0] ad_i,
    output logic             ack_o,
    output logic [BUS_W-1:0] rdata_o,
    output phase_e           phase_o,
    output logic             last_o,
    output logic             we_o,
    output logic [AW-1:0]    addr_o,
    output logic [BUS_W-1:0] wdata_o,
    output logic [1:0]       be_o,
    output bus_mode_e        mode_o,
    output logic             early_o,
    output logic             cs_rd_gate_o,
    output logic             cs_wr_gate_o
);

    localparam int CNT_W = WAIT_W + 1;
    localparam int HALF  = BUS_W / 2;

    typedef struct packed {
        phase_e            phase;
        logic [CNT_W-1:0]  cnt;
        logic              we;
        logic [AW-1:0]     addr;
        logic [BUS_W-1:0]  wdata;
        logic [1:0]        be;
        win_cfg_t          cfg;
        logic              ack;
        logic [BUS_W-1:0]  rdata;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.ack = 1'b0;
        unique case (s_q.phase)
            PH_IDLE: begin
                // no acceptance in the acknowledge cycle: requester is still dropping req
                if (req_i && !s_q.ack && cfg_i.bus_on) begin
                    s_d.phase = PH_ALE;
                    s_d.cnt   = cfg_i.ale_long ? CNT_W'(1) : '0;
                    s_d.we    = we_i;
                    s_d.addr  = addr_i;
                    s_d.wdata = wdata_i;
                    s_d.be    = be_i;
                    s_d.cfg   = cfg_i;
                end
            end
            PH_ALE: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_STRB;
                    s_d.cnt   = CNT_W'(s_q.cfg.waits) + CNT_W'(1);
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_STRB: begin
                if (s_q.cnt == '0) begin
                    if (!s_q.we) begin
                        s_d.rdata = s_q.cfg.mode[1] ? ad_i : {2{ad_i[HALF-1:0]}};
                    end
                    if (s_q.cfg.no_float_wait) begin
                        s_d.phase = PH_IDLE;
                        s_d.ack   = 1'b1;
                    end else begin
                        s_d.phase = PH_TRI;
                    end
                end else if (s_q.cnt == CNT_W'(1) && s_q.cfg.rdy_en && !ready_i) begin
                    s_d.cnt = s_q.cnt;
                end else begin
                    s_d.cnt = s_q.cnt - CNT_W'(1);
                end
            end
            PH_TRI: begin
                s_d.phase = PH_IDLE;
                s_d.ack   = 1'b1;
            end
            default: s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign ack_o        = s_q.ack;
    assign rdata_o      = s_q.rdata;
    assign phase_o      = s_q.phase;
    assign last_o       = (s_q.cnt == '0);
    assign we_o         = s_q.we;
    assign addr_o       = s_q.addr;
    assign wdata_o      = s_q.wdata;
    assign be_o         = s_q.be;
    assign mode_o       = s_q.cfg.mode;
    assign early_o      = s_q.cfg.early_wr;
    assign cs_rd_gate_o = s_q.cfg.cs_rd_gate;
    assign cs_wr_gate_o = s_q.cfg.cs_wr_gate;

endmodule

// File: rtl/ebs_pins.sv
module ebs_pins
    import ebs_pkg::*;
#(
    parameter int AW = 20
) (
    input  phase_e           phase_i,
    input  logic             last_i,
    input  logic             we_i,
    input  logic [AW-1:0]    addr_i,
    input  logic [BUS_W-1:0] wdata_i,
    input  logic [1:0]       be_i,
    input  bus_mode_e        mode_i,
    input  logic             early_i,
    input  logic             cs_rd_gate_i,
    input  logic             cs_wr_gate_i,
    output logic [AW-1:0]    addr_o,
    output logic [BUS_W-1:0] ad_o,
    output logic             ad_oe_o,
    output logic             ale_o,
    output logic             rd_o,
    output logic             wr_o,
    output logic             wrl_o,
    output logic             wrh_o,
    output logic             cs_o
);

    localparam int HALF = BUS_W / 2;

    logic             in_ale, in_strb, shared, wide, wstrb;
    logic [BUS_W-1:0] lane;

    always_comb begin
        in_ale  = (phase_i == PH_ALE);
        in_strb = (phase_i == PH_STRB);
        shared  = mode_i[0];
        wide    = mode_i[1];

        lane = wide ? wdata_i
                    : {{HALF{1'b0}}, (be_i == 2'b10) ? wdata_i[BUS_W-1:HALF] : wdata_i[HALF-1:0]};

        rd_o  = in_strb && !we_i;
        wstrb = in_strb && we_i && !(early_i && last_i);
        wr_o  = wstrb && !wide;
        wrl_o = wstrb && wide && be_i[0];
        wrh_o = wstrb && wide && be_i[1];
        ale_o = in_ale;

        ad_o    = '0;
        ad_oe_o = 1'b0;
        if (shared && in_ale) begin
            ad_o    = addr_i[BUS_W-1:0];
            ad_oe_o = 1'b1;
        end else if (we_i && (in_strb || (!shared && in_ale))) begin
            ad_o    = lane;
            ad_oe_o = 1'b1;
        end

        cs_o = in_ale || in_strb;
        if (!we_i && cs_rd_gate_i) begin
            cs_o = rd_o;
        end
        if (we_i && cs_wr_gate_i) begin
            cs_o = wstrb;
        end

        addr_o = (phase_i != PH_IDLE) ? addr_i : '0;
    end

endmodule

// File: rtl/ebs_top.sv
module ebs_top
    import ebs_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic [1:0]            strap_mode_i,
    input  logic                  cfg_we_i,
    input  logic [CFG_W-1:0]      cfg_wdata_i,
    output logic [CFG_W-1:0]      cfg_rdata_o,
    input  logic                  req_i,
    input  logic                  we_i,
    input  logic [AW-1:0]         addr_i,
    input  logic [BUS_W-1:0]      wdata_i,
    input  logic [1:0]            be_i,
    output logic                  ack_o,
    output logic [BUS_W-1:0]      rdata_o,
    output logic [AW-1:0]         addr_o,
    output logic [BUS_W-1:0]      ad_o,
    output logic                  ad_oe_o,
    input  logic [BUS_W-1:0]      ad_i,
    output logic                  ale_o,
    output logic                  rd_o,
    output logic                  wr_o,
    output logic                  wrl_o,
    output logic                  wrh_o,
    output logic                  cs_o,
    input  logic                  ready_i
);

    win_cfg_t         cfg_wr, cfg_q;
    phase_e           phase;
    logic             last, x_we, x_early, x_csrd, x_cswr;
    logic [AW-1:0]    x_addr;
    logic [BUS_W-1:0] x_wdata;
    logic [1:0]       x_be;
    bus_mode_e        x_mode;

    assign cfg_wr      = win_cfg_t'(cfg_wdata_i);
    assign cfg_rdata_o = cfg_q;

    ebs_cfg_reg u_cfg (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .strap_mode_i (strap_mode_i),
        .wr_en_i      (cfg_we_i),
        .wr_data_i    (cfg_wr),
        .cfg_o        (cfg_q)
    );

    ebs_seq #(.AW(AW)) u_seq (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .cfg_i        (cfg_q),
        .req_i        (req_i),
        .we_i         (we_i),
        .addr_i       (addr_i),
        .wdata_i      (wdata_i),
        .be_i         (be_i),
        .ready_i      (ready_i),
        .ad_i         (ad_i),
        .ack_o        (ack_o),
        .rdata_o      (rdata_o),
        .phase_o      (phase),
        .last_o       (last),
        .we_o         (x_we),
        .addr_o       (x_addr),
        .wdata_o      (x_wdata),
        .be_o         (x_be),
        .mode_o       (x_mode),
        .early_o      (x_early),
        .cs_rd_gate_o (x_csrd),
        .cs_wr_gate_o (x_cswr)
    );

    ebs_pins #(.AW(AW)) u_pins (
        .phase_i      (phase),
        .last_i       (last),
        .we_i         (x_we),
        .addr_i       (x_addr),
        .wdata_i      (x_wdata),
        .be_i         (x_be),
        .mode_i       (x_mode),
        .early_i      (x_early),
        .cs_rd_gate_i (x_csrd),
        .cs_wr_gate_i (x_cswr),
        .addr_o       (addr_o),
        .ad_o         (ad_o),
        .ad_oe_o      (ad_oe_o),
        .ale_o        (ale_o),
        .rd_o         (rd_o),
        .wr_o         (wr_o),
        .wrl_o        (wrl_o),
        .wrh_o        (wrh_o),
        .cs_o         (cs_o)
    );

endmodule

// File: rtl/ebs_chk.sv
module ebs_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic bus_on_i,
    input logic ack_o,
    input logic ad_oe_o,
    input logic ale_o,
    input logic rd_o,
    input logic wr_o,
    input logic wrl_o,
    input logic wrh_o
);

    logic any_wr;
    assign any_wr = wr_o || wrl_o || wrh_o;

    assert_rd_wr_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rd_o && any_wr));

    assert_ack_pulse_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> !ack_o);

    assert_wr_width_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_o && (wrl_o || wrh_o)));

    assert_ale_no_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(ale_o && (rd_o || any_wr)));

    assert_strobe_after_ale_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rd_o) |-> $past(ale_o));

    assert_read_float_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_o |-> !ad_oe_o);

    assert_bus_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ale_o) |-> $past(bus_on_i));

endmodule

bind ebs_top ebs_chk chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .bus_on_i (cfg_rdata_o[12]),
    .ack_o    (ack_o),
    .ad_oe_o  (ad_oe_o),
    .ale_o    (ale_o),
    .rd_o     (rd_o),
    .wr_o     (wr_o),
    .wrl_o    (wrl_o),
    .wrh_o    (wrh_o)
);

// File: tb/ebs_top_tb_top.sv
module ebs_top_tb_top;
    import ebs_pkg::*;

    localparam int AW = 20;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [1:0]       strap;
    logic             cfg_we;
    logic [CFG_W-1:0] cfg_wdata, cfg_rdata;
    logic             req, we;
    logic [AW-1:0]    addr, addr_o;
    logic [15:0]      wdata, rdata, ad_o, ad_i;
    logic [1:0]       be;
    logic             ack, ad_oe, ale, rd, wr, wrl, wrh, cs, ready;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    // external memory model: returns a pattern derived from the address
    assign ad_i = {addr_o[7:0] ^ 8'hA5, addr_o[7:0] ^ 8'h3C};

    ebs_top #(.AW(AW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .strap_mode_i(strap),
        .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata),
        .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata), .be_i(be),
        .ack_o(ack), .rdata_o(rdata), .addr_o(addr_o), .ad_o(ad_o),
        .ad_oe_o(ad_oe), .ad_i(ad_i), .ale_o(ale), .rd_o(rd), .wr_o(wr),
        .wrl_o(wrl), .wrh_o(wrh), .cs_o(cs), .ready_i(ready)
    );

    // bit order: on, wr-gate, rd-gate, ready, long ALE, early, skip-float, waits[3:0], mode[1:0]
    function automatic logic [CFG_W-1:0] cfgv(bit on, bit cswr, bit csrd, bit rdy, bit alel,
                                              bit early, bit nofl, int waits, int mode);
        return {on, cswr, csrd, rdy, alel, early, nofl, WAIT_W'(waits), 2'(mode)};
    endfunction

    typedef struct packed {
        logic [CFG_W-1:0] cfg;
        logic             we;
        logic [15:0]      addr;
        logic [15:0]      wdata;
        logic [1:0]       be;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{cfgv(1,0,0,0,1,0,0, 0,0), 1'b0, 16'h1234, 16'h0000, 2'b11},
        '{cfgv(1,0,0,0,0,1,1, 2,1), 1'b1, 16'h0456, 16'hA55A, 2'b01},
        '{cfgv(1,0,1,0,1,0,1, 3,3), 1'b0, 16'h7788, 16'h0000, 2'b11},
        '{cfgv(1,1,0,0,0,0,0, 1,2), 1'b1, 16'h2001, 16'h1F2E, 2'b10},
        '{cfgv(1,1,0,0,0,1,0, 0,3), 1'b1, 16'h3AB0, 16'hBEEF, 2'b11},
        '{cfgv(1,0,0,0,1,0,0, 4,0), 1'b1, 16'h00F1, 16'hC3D4, 2'b10},
        '{cfgv(1,0,0,1,0,0,1,15,2), 1'b0, 16'h5566, 16'h0000, 2'b11},
        '{cfgv(1,0,0,0,1,0,0, 0,3), 1'b1, 16'h4444, 16'h9876, 2'b01}
    };

    int m_ale, m_rd, m_wr, m_wrl, m_wrh, m_cs, m_lat, m_rd_drive, m_addr_bad, m_strb;
    logic [16:0] m_ale_ad, m_wr_ad;

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] s);
        rst_n = 1'b0;
        strap = s;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic cfg_write(input logic [CFG_W-1:0] v);
        cfg_wdata = v;
        cfg_we    = 1'b1;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    // rdy_mode: 0 ready high, 1 ready low until 5 strobe cycles seen, 2 ready low throughout
    task automatic run(input logic w, input logic [15:0] a, input logic [15:0] d,
                       input logic [1:0] b, input int rdy_mode);
        we = w; addr = {4'h1, a}; wdata = d; be = b; req = 1'b1;
        ready = (rdy_mode == 0);
        m_ale = 0; m_rd = 0; m_wr = 0; m_wrl = 0; m_wrh = 0; m_cs = 0;
        m_lat = -1; m_rd_drive = 0; m_addr_bad = 0; m_strb = 0;
        m_ale_ad = 17'h1FFFF; m_wr_ad = 17'h1FFFF;
        for (int k = 1; k <= 200; k++) begin
            @(negedge clk);
            if (ale) begin
                m_ale++;
                if (m_ale == 1) m_ale_ad = {ad_oe, ad_oe ? ad_o : 16'h0};
            end
            if (rd) begin
                m_rd++;
                if (ad_oe) m_rd_drive++;
            end
            if ((wr || wrl || wrh) && m_wr_ad == 17'h1FFFF) m_wr_ad = {ad_oe, ad_o};
            if (wr)  m_wr++;
            if (wrl) m_wrl++;
            if (wrh) m_wrh++;
            if (cs)  m_cs++;
            if (rd || wr || wrl || wrh) m_strb++;
            if ((ale || rd || wr || wrl || wrh || cs) && addr_o != addr) m_addr_bad++;
            if (rdy_mode == 1 && m_strb == 5) ready = 1'b1;
            if (ack) begin
                m_lat = k;
                break;
            end
        end
        req = 1'b0;
        ready = 1'b1;
    endtask

    task automatic expect_cycle(input string tg, input logic [CFG_W-1:0] c, input logic w,
                                input logic [15:0] a, input logic [15:0] d, input logic [1:0] b,
                                input int extra, input int rdy_mode);
        int alen, slen, flt, wstr, cse;
        logic wide, shared;
        logic [15:0] lane, rexp;
        wide   = c[1];
        shared = c[0];
        alen   = c[8] ? 2 : 1;
        slen   = int'(c[5:2]) + 2;
        if (rdy_mode == 1 && c[9]) slen = ((int'(c[5:2]) > 4) ? int'(c[5:2]) : 4) + 2;
        flt    = c[6] ? 0 : 1;
        wstr   = w ? slen - int'(c[7]) : 0;
        lane   = wide ? d : {8'h00, (b == 2'b10) ? d[15:8] : d[7:0]};
        if (w) cse = c[11] ? wstr : alen + slen;
        else   cse = c[10] ? slen : alen + slen;
        rexp   = wide ? {a[7:0] ^ 8'hA5, a[7:0] ^ 8'h3C} : {2{a[7:0] ^ 8'h3C}};

        chk({tg, " R4 ALE cycles"}, m_ale, alen);
        chk({tg, " R5/R8/R12 RD cycles"}, m_rd, w ? 0 : slen);
        chk({tg, " R11/R7 WR cycles"}, m_wr, wide ? 0 : wstr);
        chk({tg, " R11/R7 WRL cycles"}, m_wrl, (wide && b[0]) ? wstr : 0);
        chk({tg, " R11/R7 WRH cycles"}, m_wrh, (wide && b[1]) ? wstr : 0);
        chk({tg, " R9 CS cycles"}, m_cs, cse);
        chk({tg, " R6 ack latency"}, m_lat, alen + slen + flt + 1 + extra);
        chk({tg, " R3 AD during ALE"}, int'(m_ale_ad),
            shared ? int'({1'b1, a}) : (w ? int'({1'b1, lane}) : 0));
        chk({tg, " R3 AD during write"}, int'(m_wr_ad), w ? int'({1'b1, lane}) : 32'h1FFFF);
        chk({tg, " R3 AD float on read"}, m_rd_drive, 0);
        chk({tg, " R3 address held"}, m_addr_bad, 0);
        if (!w) chk({tg, " R2 read data"}, int'(rdata), int'(rexp));
    endtask

    initial begin
        int seen_ale, seen_ack;
        rst_n = 1'b0; strap = 2'b00; cfg_we = 1'b0; cfg_wdata = '0;
        req = 1'b0; we = 1'b0; addr = '0; wdata = '0; be = 2'b00; ready = 1'b1;

        // R1 reset value with two strap settings
        do_reset(2'b01);
        chk("R1 reset cfg strap 01", int'(cfg_rdata), 13'h1101);
        chk("R12 idle after reset", int'({ack, ale, rd, wr, wrl, wrh, cs, ad_oe}), 0);
        do_reset(2'b11);
        chk("R1 reset cfg strap 11", int'(cfg_rdata), 13'h1103);

        // reset configuration in use
        run(1'b0, 16'h00AB, 16'h0, 2'b11, 0);
        expect_cycle("reset-cfg", 13'h1103, 1'b0, 16'h00AB, 16'h0, 2'b11, 0, 0);

        // vector table
        for (int i = 0; i < 8; i++) begin
            cfg_write(VECS[i].cfg);
            chk("R1 cfg write", int'(cfg_rdata), int'(VECS[i].cfg));
            run(VECS[i].we, VECS[i].addr, VECS[i].wdata, VECS[i].be, 0);
            expect_cycle($sformatf("vec%0d", i), VECS[i].cfg, VECS[i].we, VECS[i].addr,
                         VECS[i].wdata, VECS[i].be, 0, 0);
        end

        // R8 READY stretches the strobe
        cfg_write(cfgv(1,0,0,1,0,0,1,1,3));
        run(1'b0, 16'h0042, 16'h0, 2'b11, 1);
        expect_cycle("R8 stretch", cfgv(1,0,0,1,0,0,1,1,3), 1'b0, 16'h0042, 16'h0, 2'b11, 0, 1);

        // R8 READY ignored when disabled
        cfg_write(cfgv(1,0,0,0,0,0,1,1,3));
        run(1'b0, 16'h0043, 16'h0, 2'b11, 2);
        expect_cycle("R8 ignored", cfgv(1,0,0,0,0,0,1,1,3), 1'b0, 16'h0043, 16'h0, 2'b11, 0, 2);

        // R12 back-to-back requests
        cfg_write(cfgv(1,0,0,0,0,0,1,0,2));
        run(1'b0, 16'h0101, 16'h0, 2'b11, 0);
        expect_cycle("R12 first", cfgv(1,0,0,0,0,0,1,0,2), 1'b0, 16'h0101, 16'h0, 2'b11, 0, 0);
        run(1'b1, 16'h0202, 16'h6789, 2'b11, 0);
        expect_cycle("R12 second", cfgv(1,0,0,0,0,0,1,0,2), 1'b1, 16'h0202, 16'h6789, 2'b11, 1, 0);

        // R10 bus disabled holds the request
        cfg_write(cfgv(0,0,0,0,0,0,1,0,3));
        req = 1'b1; we = 1'b0; addr = {4'h1, 16'h0303};
        seen_ale = 0; seen_ack = 0;
        for (int k = 0; k < 8; k++) begin
            @(negedge clk);
            if (ale) seen_ale++;
            if (ack) seen_ack++;
        end
        chk("R10 no ALE while off", seen_ale, 0);
        chk("R10 no ack while off", seen_ack, 0);
        cfg_write(cfgv(1,0,0,0,0,0,1,0,3));
        run(1'b0, 16'h0303, 16'h0, 2'b11, 0);
        expect_cycle("R10 resumed", cfgv(1,0,0,0,0,0,1,0,3), 1'b0, 16'h0303, 16'h0, 2'b11, 0, 0);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule